// File: doc/BRIEF.md
# Agent-Gated Key Register Bank

This block stores a 128-bit cipher key as four 32-bit words behind a simple register bus. Each access carries a 5-bit agent identity. Reads and writes are authorized separately. A read-permission mask decides every read, and a write-permission mask decides every write. Both masks have one bit for each agent.

Both masks sit at their own bus addresses, next to the key words. A mask can be changed only by an agent that already holds write permission. An agent without write rights therefore cannot widen its own access. A denied or unmapped access never exposes stored data, and it never changes any register.

Read data and the deny flag are registered. Both appear one clock after the request. A write takes effect at the clock edge that samples it.

Top module: `keybank_gate`

## Requirements
- R1: The key is held in four 32-bit words. Address k (0 to 3) holds key bits 32k+31 down to 32k. All four words reset to 0x00000000.
- R2: The read mask is at address 4 and the write mask is at address 5. The read mask resets to 0x00000002, so only agent 1 may read. The write mask resets to 0x00000004, so only agent 2 may write.
- R3: Bit n of a mask governs the agent whose identity is n, for n from 0 to 31. A bit at 1 permits the action for that agent and a bit at 0 forbids it.
- R4: A read of any mapped address (0 to 5) is decided only by the read mask. The data of a granted read appears on rdata_o one clock after the request, with deny_o low.
- R5: A denied read drives rdata_o to zero and deny_o high in the clock after the request.
- R6: A write to any mapped address, key word or mask, is decided only by the write mask. A granted write takes effect at the sampling edge, so a read in the next cycle returns the new value.
- R7: A denied write leaves every key word and both masks unchanged. deny_o is high in the following clock.
- R8: An access to an unmapped address (6 to 15) raises deny_o in the next clock, returns zero and changes nothing.
- R9: When read and write enables are high in the same cycle, both must be granted. If both are granted, the read returns the value held before the write and the write takes effect. If either is denied, neither is carried out: rdata_o is zero and deny_o is high.
- R10: When no read was granted in the previous cycle, rdata_o is zero. When no access was requested in the previous cycle, deny_o is low.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Word address |
| wr_en_i | input | 1 | Write request |
| rd_en_i | input | 1 | Read request |
| wdata_i | input | 32 | Write data |
| agent_id_i | input | 5 | Identity of the requesting agent |
| rdata_o | output | 32 | Registered read data, zero unless a read was granted |
| deny_o | output | 1 | Registered flag: previous access was refused |

## Verification
A read and a write can fall in the same cycle at the same address. The read must then return the value held before the write, and the two permission checks must combine so that one refused half cancels the other. This is provoked by raising both enables together on key word 0, first for an agent that may read but not write, then for an agent holding both rights. The first case is judged by zero data, a raised deny flag and an unchanged word on the next read. The second is judged by the old word being returned and the new word appearing on the following read.

// File: rtl/keybank_pkg.sv
package keybank_pkg;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_WORDS = 4;
  localparam int unsigned AGENT_W   = 5;
  localparam int unsigned NUM_AGENTS = 2 ** AGENT_W;
  localparam logic [DATA_W-1:0] RMASK_RST = 32'h0000_0002;
  localparam logic [DATA_W-1:0] WMASK_RST = 32'h0000_0004;
endpackage

// File: rtl/keybank_dec.sv
module keybank_dec #(
  parameter int unsigned ADDR_W    = keybank_pkg::ADDR_W,
  parameter int unsigned NUM_WORDS = keybank_pkg::NUM_WORDS
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_WORDS-1:0] key_sel_o,
  output logic                 rmask_sel_o,
  output logic                 wmask_sel_o,
  output logic                 hit_o
);
  localparam logic [ADDR_W-1:0] RMASK_ADDR = ADDR_W'(NUM_WORDS);
  localparam logic [ADDR_W-1:0] WMASK_ADDR = ADDR_W'(NUM_WORDS + 1);

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_sel
    assign key_sel_o[k] = (addr_i == ADDR_W'(k));
  end

  assign rmask_sel_o = (addr_i == RMASK_ADDR);
  assign wmask_sel_o = (addr_i == WMASK_ADDR);
  assign hit_o       = (|key_sel_o) | rmask_sel_o | wmask_sel_o;

  always_comb begin
    a_sel_onehot: assert ($onehot0({key_sel_o, rmask_sel_o, wmask_sel_o}));
  end
endmodule

// File: rtl/keybank_policy.sv
module keybank_policy #(
  parameter int unsigned AGENT_W = keybank_pkg::AGENT_W,
  parameter int unsigned DATA_W  = keybank_pkg::DATA_W,
  parameter logic [DATA_W-1:0] RMASK_RST = keybank_pkg::RMASK_RST,
  parameter logic [DATA_W-1:0] WMASK_RST = keybank_pkg::WMASK_RST
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AGENT_W-1:0] agent_id_i,
  input  logic               we_i,
  input  logic               rmask_sel_i,
  input  logic               wmask_sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rmask_o,
  output logic [DATA_W-1:0]  wmask_o,
  output logic               rd_ok_o,
  output logic               wr_ok_o
);
  logic [DATA_W-1:0] rmask_q, wmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rmask_q <= RMASK_RST;
      wmask_q <= WMASK_RST;
    end else if (we_i) begin
      if (rmask_sel_i) rmask_q <= wdata_i;
      if (wmask_sel_i) wmask_q <= wdata_i;
    end
  end

  assign rmask_o = rmask_q;
  assign wmask_o = wmask_q;
  assign rd_ok_o = rmask_q[agent_id_i];
  assign wr_ok_o = wmask_q[agent_id_i];

  // masks move only on an authorized write (R6, R7)
  p_mask_guard_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && wr_ok_o) |=> $stable(rmask_q) && $stable(wmask_q));
endmodule

// File: rtl/keybank_store.sv
module keybank_store #(
  parameter int unsigned DATA_W    = keybank_pkg::DATA_W,
  parameter int unsigned NUM_WORDS = keybank_pkg::NUM_WORDS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [NUM_WORDS-1:0]        key_sel_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [NUM_WORDS*DATA_W-1:0] key_o
);
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  word_q <= '0;
      else if (we_i && key_sel_i[k]) word_q <= wdata_i;
    end
    assign key_o[k*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/keybank_gate.sv
module keybank_gate
  import keybank_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [AGENT_W-1:0] agent_id_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               deny_o
);
  logic [NUM_WORDS-1:0]        key_sel;
  logic                        rmask_sel, wmask_sel, hit;
  logic [DATA_W-1:0]           rmask, wmask;
  logic                        rd_ok, wr_ok;
  logic [NUM_WORDS*DATA_W-1:0] key;
  logic                        req, grant, wr_grant, rd_grant;
  logic [DATA_W-1:0]           rd_val;
  logic [DATA_W-1:0]           rdata_q;
  logic                        deny_q;

  keybank_dec #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
    .addr_i      (addr_i),
    .key_sel_o   (key_sel),
    .rmask_sel_o (rmask_sel),
    .wmask_sel_o (wmask_sel),
    .hit_o       (hit)
  );

  // a combined access is all-or-nothing
  assign req      = rd_en_i | wr_en_i;
  assign grant    = req & hit & (~rd_en_i | rd_ok) & (~wr_en_i | wr_ok);
  assign wr_grant = grant & wr_en_i;
  assign rd_grant = grant & rd_en_i;

  keybank_policy #(.AGENT_W(AGENT_W), .DATA_W(DATA_W)) u_policy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .agent_id_i  (agent_id_i),
    .we_i        (wr_grant),
    .rmask_sel_i (rmask_sel),
    .wmask_sel_i (wmask_sel),
    .wdata_i     (wdata_i),
    .rmask_o     (rmask),
    .wmask_o     (wmask),
    .rd_ok_o     (rd_ok),
    .wr_ok_o     (wr_ok)
  );

  keybank_store #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_grant),
    .key_sel_i (key_sel),
    .wdata_i   (wdata_i),
    .key_o     (key)
  );

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (key_sel[k]) rd_val = key[k*DATA_W +: DATA_W];
    if (rmask_sel) rd_val = rmask;
    if (wmask_sel) rd_val = wmask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      deny_q  <= 1'b0;
    end else begin
      rdata_q <= rd_grant ? rd_val : '0;
      deny_q  <= req & ~grant;
    end
  end

  assign rdata_o = rdata_q;
  assign deny_o  = deny_q;

  p_deny_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o |-> rdata_o == '0);
  p_rd_refused_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !rmask[agent_id_i] |=> deny_o);
  p_wr_granted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && hit && wmask[agent_id_i] && (!rd_en_i || rmask[agent_id_i]) |=> !deny_o);
  p_key_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wmask[agent_id_i] |=> $stable(key));
  p_unmapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req && !hit |=> deny_o && rdata_o == '0 && $stable(key));
  p_pair_cancel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && wr_en_i && !wmask[agent_id_i] |=> deny_o && $stable(key));
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req |=> rdata_o == '0 && !deny_o);
endmodule

// File: tb/keybank_gate_test.sv
module keybank_gate_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [4:0]  agent = '0;
  logic [31:0] rdata;
  logic        deny;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  keybank_gate uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .agent_id_i(agent), .rdata_o(rdata), .deny_o(deny)
  );

  typedef struct packed {
    logic [3:0]  addr;
    logic        wr;
    logic        rd;
    logic [4:0]  agent;
    logic [31:0] wdata;
    logic [31:0] exp_rdata;
    logic        exp_deny;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 1'b0, 1'b1, 5'd1,  32'h0,         32'h0,         1'b0, 8'd1},  // R1 reset word
    '{4'd0, 1'b1, 1'b0, 5'd2,  32'hA5A5_0001, 32'h0,         1'b0, 8'd6},  // R6
    '{4'd0, 1'b0, 1'b1, 5'd1,  32'h0,         32'hA5A5_0001, 1'b0, 8'd4},  // R4
    '{4'd0, 1'b0, 1'b1, 5'd2,  32'h0,         32'h0,         1'b1, 8'd5},  // R5 writer cannot read
    '{4'd1, 1'b1, 1'b0, 5'd1,  32'hDEAD_BEEF, 32'h0,         1'b1, 8'd7},  // R7
    '{4'd1, 1'b0, 1'b1, 5'd1,  32'h0,         32'h0,         1'b0, 8'd7},  // R7 unchanged
    '{4'd3, 1'b1, 1'b0, 5'd2,  32'h1234_5678, 32'h0,         1'b0, 8'd6},  // R6
    '{4'd3, 1'b0, 1'b1, 5'd1,  32'h0,         32'h1234_5678, 1'b0, 8'd1},  // R1 top word
    '{4'd4, 1'b0, 1'b1, 5'd1,  32'h0,         32'h0000_0002, 1'b0, 8'd2},  // R2
    '{4'd5, 1'b0, 1'b1, 5'd1,  32'h0,         32'h0000_0004, 1'b0, 8'd2},  // R2
    '{4'd6, 1'b0, 1'b1, 5'd1,  32'h0,         32'h0,         1'b1, 8'd8},  // R8
    '{4'd9, 1'b1, 1'b0, 5'd2,  32'hFFFF_FFFF, 32'h0,         1'b1, 8'd8},  // R8
    '{4'd4, 1'b1, 1'b0, 5'd7,  32'hFFFF_FFFF, 32'h0,         1'b1, 8'd7},  // R7 mask widen
    '{4'd4, 1'b0, 1'b1, 5'd1,  32'h0,         32'h0000_0002, 1'b0, 8'd7},  // R7 mask kept
    '{4'd0, 1'b1, 1'b1, 5'd1,  32'h0,         32'h0,         1'b1, 8'd9},  // R9 half refused
    '{4'd0, 1'b0, 1'b1, 5'd1,  32'h0,         32'hA5A5_0001, 1'b0, 8'd9},  // R9 no write
    '{4'd5, 1'b1, 1'b0, 5'd2,  32'h0000_0006, 32'h0,         1'b0, 8'd6},  // R6 mask write
    '{4'd4, 1'b1, 1'b0, 5'd2,  32'h0000_0006, 32'h0,         1'b0, 8'd6},  // R6
    '{4'd0, 1'b1, 1'b1, 5'd2,  32'h0BAD_F00D, 32'hA5A5_0001, 1'b0, 8'd9},  // R9 old value
    '{4'd0, 1'b0, 1'b1, 5'd1,  32'h0,         32'h0BAD_F00D, 1'b0, 8'd9},  // R9 new value
    '{4'd2, 1'b1, 1'b0, 5'd1,  32'h2222_2222, 32'h0,         1'b0, 8'd3},  // R3
    '{4'd2, 1'b0, 1'b1, 5'd2,  32'h0,         32'h2222_2222, 1'b0, 8'd3},  // R3
    '{4'd0, 1'b0, 1'b0, 5'd0,  32'h0,         32'h0,         1'b0, 8'd10}, // R10 idle
    '{4'd5, 1'b1, 1'b0, 5'd2,  32'h0000_0002, 32'h0,         1'b0, 8'd3},  // R3
    '{4'd2, 1'b1, 1'b0, 5'd2,  32'h0,         32'h0,         1'b1, 8'd3},  // R3 bit cleared
    '{4'd2, 1'b0, 1'b1, 5'd1,  32'h0,         32'h2222_2222, 1'b0, 8'd7},  // R7
    '{4'd0, 1'b0, 1'b1, 5'd31, 32'h0,         32'h0,         1'b1, 8'd3},  // R3 agent 31
    '{4'd4, 1'b1, 1'b0, 5'd1,  32'h8000_0000, 32'h0,         1'b0, 8'd3},  // R3
    '{4'd0, 1'b0, 1'b1, 5'd31, 32'h0,         32'h0BAD_F00D, 1'b0, 8'd3}   // R3 bit 31
  };

  task automatic check(input int req, input logic [31:0] exp_r, input logic exp_d);
    n_chk++;
    if (rdata !== exp_r || deny !== exp_d) begin
      n_bad++;
      $display("FAIL R%0d: rdata=%h deny=%b expected rdata=%h deny=%b",
               req, rdata, deny, exp_r, exp_d);
    end
  endtask

  // drive after a falling edge, sample at the next falling edge
  task automatic op(input logic [3:0] a, input logic w, input logic r,
                    input logic [4:0] ag, input logic [31:0] d);
    addr = a; wr_en = w; rd_en = r; agent = ag; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(10, 32'h0, 1'b0); // R10 outputs under reset
    rst_ni = 1'b1;
    @(negedge clk);
    check(10, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].addr, VEC[i].wr, VEC[i].rd, VEC[i].agent, VEC[i].wdata);
      check(int'(VEC[i].req), VEC[i].exp_rdata, VEC[i].exp_deny);
    end

    // R1 R2: reset restores words and masks
    rst_ni = 1'b0;
    @(negedge clk);
    check(2, 32'h0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    op(4'd0, 1'b0, 1'b1, 5'd1, 32'h0);  check(1, 32'h0, 1'b0);
    op(4'd4, 1'b0, 1'b1, 5'd1, 32'h0);  check(2, 32'h0000_0002, 1'b0);
    op(4'd5, 1'b0, 1'b1, 5'd1, 32'h0);  check(2, 32'h0000_0004, 1'b0);
    op(4'd0, 1'b0, 1'b1, 5'd31, 32'h0); check(3, 32'h0, 1'b1);
    // R8 last unmapped address, writer present
    op(4'd15, 1'b1, 1'b1, 5'd2, 32'h1); check(8, 32'h0, 1'b1);
    op(4'd0, 1'b0, 1'b0, 5'd0, 32'h0);  check(10, 32'h0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule